// File: doc/BRIEF.md
# Programmable Conversion Sequencer Memory

This block holds a short list of conversion steps for a multi-channel converter front end and plays that list back one step per conversion. Each step carries six configuration bits: a differential-pair select, a three-bit multiplexer channel address, a unipolar/bipolar span select and a gain select. A seventh bit per step marks the last step of the list. The block sets and clears that bit itself while the list is written; the user never supplies it.

In program mode, every write strobe stores the configuration inputs at the next free location. In run mode, every falling edge of the active-low conversion-start input moves playback to the next step. After the marked last step, playback returns to location 0. The configuration of the current step drives the multiplexer and span outputs. In readback mode, a separate cursor walks the memory, and each stored word is presented as a 7-bit status word, so software can check what was programmed. An idle mode freezes all of this.

Top module: `conv_seq_mem`

## Requirements
- R1: After reset, every location holds zero, except that location 0 has its end-of-sequence bit set. Both the playback and readback cursors sit at location 0, so `cfg_o` reads 0 and `status_o` reads 7'b0000001.
- R2: In program mode (`mode_i` = 2'b01), each cycle with `wr_i` high stores `{cfg_i, 1'b1}` at the next location and clears bit 0 of the previous location. A status word is laid out as bit 6 diff, bit 5..3 channel address (high to low), bit 2 unipolar, bit 1 gain, bit 0 end-of-sequence, and `cfg_i` uses the same order in bits 5..0.
- R3: Each entry into program mode restarts writing at location 0.
- R4: Once all 16 locations are written, further writes in the same program session are ignored, and location 15 keeps its end-of-sequence bit.
- R5: `wr_i` outside program mode changes no location.
- R6: In run mode (`mode_i` = 2'b00), `cfg_o` shows bits 6..1 of the current playback location. Each falling edge of `conv_start_n_i` advances playback by one location. Entering run mode returns playback to location 0, and falling edges in any other mode do not move it.
- R7: A falling edge taken at a location whose end-of-sequence bit is set, or at location 15, returns playback to location 0.
- R8: In readback mode (`mode_i` = 2'b10), `status_o` shows the word at the readback cursor. Entering the mode puts the cursor at location 0, and each cycle with `rd_i` high advances it by one, with location 15 followed by location 0. `rd_i` outside readback mode is ignored.
- R9: In idle mode (`mode_i` = 2'b11), write strobes, read strobes and conversion starts change neither the memory nor either cursor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | 00 run, 01 program, 10 readback, 11 idle |
| wr_i | input | 1 | Write strobe, one store per high cycle in program mode |
| cfg_i | input | 6 | Step configuration {diff, addr[2:0], unipolar, gain} |
| conv_start_n_i | input | 1 | Active-low conversion start; the falling edge advances playback |
| rd_i | input | 1 | Readback strobe, one advance per high cycle in readback mode |
| cfg_o | output | 6 | Configuration of the current playback step |
| status_o | output | 7 | Stored word at the readback cursor |

## Verification
The hardest states to reach are a full memory with a seventeenth write arriving, and a session that re-enters program mode and writes a list shorter than the one before, so that stale words lie past the new end marker. Directed sequences build both cases. Seeded random rounds then write lists of 1 to 17 steps and scatter strobes that the current mode must ignore. Playback runs longer than each list so that every wrap is taken, and readback runs through location 15 into location 0.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;
    typedef enum logic [1:0] {
        MODE_RUN  = 2'b00,
        MODE_PROG = 2'b01,
        MODE_READ = 2'b10,
        MODE_IDLE = 2'b11
    } seq_mode_e;
endpackage

// File: rtl/seq_mode_track.sv
module seq_mode_track
    import conv_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       conv_start_n_i,
    output logic       prog_act_o,
    output logic       run_act_o,
    output logic       read_act_o,
    output logic       enter_prog_o,
    output logic       enter_run_o,
    output logic       enter_read_o,
    output logic       conv_fall_o
);
    typedef struct packed {
        logic [1:0] mode;
        logic       conv_n;
    } track_t;

    track_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.mode   = mode_i;
        st_d.conv_n = conv_start_n_i;
        prog_act_o   = (mode_i == MODE_PROG);
        run_act_o    = (mode_i == MODE_RUN);
        read_act_o   = (mode_i == MODE_READ);
        enter_prog_o = prog_act_o && (st_q.mode != MODE_PROG);
        enter_run_o  = run_act_o && (st_q.mode != MODE_RUN);
        enter_read_o = read_act_o && (st_q.mode != MODE_READ);
        conv_fall_o  = st_q.conv_n && !conv_start_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode   <= MODE_RUN;
            st_q.conv_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: an edge is reported only when the input was high in the previous cycle and is low now
    a_r6_fall_only_from_high: assert property (@(posedge clk) disable iff (!rst_n)
        conv_fall_o |=> !$past(conv_start_n_i) && (st_q.conv_n == 1'b0));
endmodule

// File: rtl/seq_store.sv
module seq_store #(
    parameter int DEPTH = 16,
    parameter int CFG_W = 6
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     prog_act_i,
    input  logic                     enter_prog_i,
    input  logic                     wr_i,
    input  logic [CFG_W-1:0]         cfg_i,
    input  logic [$clog2(DEPTH)-1:0] run_idx_i,
    input  logic [$clog2(DEPTH)-1:0] rd_idx_i,
    output logic [CFG_W:0]           run_word_o,
    output logic [CFG_W:0]           rd_word_o
);
    localparam int AW     = $clog2(DEPTH);
    localparam int CNT_W  = AW + 1;
    localparam int WORD_W = CFG_W + 1;

    typedef struct packed {
        logic [DEPTH-1:0][WORD_W-1:0] mem;
        logic [CNT_W-1:0]             cnt;
    } store_t;

    store_t           st_d, st_q;
    logic [CNT_W-1:0] base;
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    prev_idx;
    logic             accept;

    always_comb begin
        base     = enter_prog_i ? '0 : st_q.cnt;
        wr_idx   = base[AW-1:0];
        prev_idx = wr_idx - AW'(1);
        accept   = prog_act_i && wr_i && (base < CNT_W'(DEPTH));
        st_d     = st_q;
        st_d.cnt = base;
        if (accept) begin
            if (base != '0) begin
                st_d.mem[prev_idx][0] = 1'b0;
            end
            st_d.mem[wr_idx] = {cfg_i, 1'b1};
            st_d.cnt         = base + CNT_W'(1);
        end
        run_word_o = st_q.mem[run_idx_i];
        rd_word_o  = st_q.mem[rd_idx_i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mem       <= '0;
            st_q.mem[0][0] <= 1'b1;
            st_q.cnt       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R2: an accepted write lands with its end marker set and the configuration intact
    a_r2_store_word: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> st_q.mem[$past(wr_idx)] == {$past(cfg_i), 1'b1});
    // R2: the location written just before loses its end marker
    a_r2_prev_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && base != '0) |=> !st_q.mem[$past(prev_idx)][0]);
    // R4: a full memory in the same session is left untouched
    a_r4_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_act_i && !enter_prog_i && st_q.cnt == CNT_W'(DEPTH)) |=> $stable(st_q.mem));
    // R5: outside program mode the memory never changes
    a_r5_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !prog_act_i |=> $stable(st_q.mem));
endmodule

// File: rtl/seq_cursor.sv
module seq_cursor #(
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run_act_i,
    input  logic                     enter_run_i,
    input  logic                     conv_fall_i,
    input  logic                     run_eos_i,
    input  logic                     read_act_i,
    input  logic                     enter_read_i,
    input  logic                     rd_i,
    output logic [$clog2(DEPTH)-1:0] run_idx_o,
    output logic [$clog2(DEPTH)-1:0] rd_idx_o
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] run;
        logic [AW-1:0] rd;
    } cursor_t;

    cursor_t st_d, st_q;
    logic    run_step;
    logic    rd_step;

    always_comb begin
        st_d     = st_q;
        run_step = run_act_i && !enter_run_i && conv_fall_i;
        rd_step  = read_act_i && !enter_read_i && rd_i;
        if (enter_run_i) begin
            st_d.run = '0;
        end else if (run_step) begin
            st_d.run = (run_eos_i || st_q.run == LAST) ? '0 : st_q.run + AW'(1);
        end
        if (enter_read_i) begin
            st_d.rd = '0;
        end else if (rd_step) begin
            st_d.rd = (st_q.rd == LAST) ? '0 : st_q.rd + AW'(1);
        end
        run_idx_o = st_q.run;
        rd_idx_o  = st_q.rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6: playback moves only on a run-mode edge or on entry to run mode
    a_r6_run_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_act_i && conv_fall_i) && !enter_run_i |=> $stable(st_q.run));
    // R7: an edge at a marked step returns playback to the start
    a_r7_wrap_after_eos: assert property (@(posedge clk) disable iff (!rst_n)
        (run_step && run_eos_i) |=> st_q.run == '0);
    // R8: entering readback starts at location 0
    a_r8_read_enter: assert property (@(posedge clk) disable iff (!rst_n)
        enter_read_i |=> st_q.rd == '0);
    // R8: a read strobe below the top location steps the cursor by one
    a_r8_read_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && st_q.rd != LAST) |=> st_q.rd == $past(st_q.rd) + AW'(1));
endmodule

// File: rtl/conv_seq_mem.sv
module conv_seq_mem #(
    parameter int DEPTH = 16,
    parameter int CFG_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_i,
    input  logic             wr_i,
    input  logic [CFG_W-1:0] cfg_i,
    input  logic             conv_start_n_i,
    input  logic             rd_i,
    output logic [CFG_W-1:0] cfg_o,
    output logic [CFG_W:0]   status_o
);
    localparam int AW = $clog2(DEPTH);

    logic          prog_act, run_act, read_act;
    logic          enter_prog, enter_run, enter_read;
    logic          conv_fall;
    logic [AW-1:0] run_idx, rd_idx;
    logic [CFG_W:0] run_word, rd_word;

    seq_mode_track u_track (
        .clk            (clk),
        .rst_n          (rst_n),
        .mode_i         (mode_i),
        .conv_start_n_i (conv_start_n_i),
        .prog_act_o     (prog_act),
        .run_act_o      (run_act),
        .read_act_o     (read_act),
        .enter_prog_o   (enter_prog),
        .enter_run_o    (enter_run),
        .enter_read_o   (enter_read),
        .conv_fall_o    (conv_fall)
    );

    seq_store #(.DEPTH(DEPTH), .CFG_W(CFG_W)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .prog_act_i   (prog_act),
        .enter_prog_i (enter_prog),
        .wr_i         (wr_i),
        .cfg_i        (cfg_i),
        .run_idx_i    (run_idx),
        .rd_idx_i     (rd_idx),
        .run_word_o   (run_word),
        .rd_word_o    (rd_word)
    );

    seq_cursor #(.DEPTH(DEPTH)) u_cursor (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_act_i    (run_act),
        .enter_run_i  (enter_run),
        .conv_fall_i  (conv_fall),
        .run_eos_i    (run_word[0]),
        .read_act_i   (read_act),
        .enter_read_i (enter_read),
        .rd_i         (rd_i),
        .run_idx_o    (run_idx),
        .rd_idx_o     (rd_idx)
    );

    assign cfg_o    = run_word[CFG_W:1];
    assign status_o = rd_word;

    // R9: in idle mode both outputs hold
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'b11 && $past(mode_i) == 2'b11) |=> $stable(cfg_o) && $stable(status_o));
endmodule

// File: tb/conv_seq_mem_test.sv
module conv_seq_mem_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       wr = 1'b0;
    logic [5:0] cfg = '0;
    logic       conv_n = 1'b1;
    logic       rd = 1'b0;
    logic [5:0] cfg_o;
    logic [6:0] status_o;

    int   checks = 0;
    int   fails = 0;
    bit   done = 1'b0;

    logic [6:0] m [16];
    int         wcnt, rp, rdp;
    logic [1:0] cur_mode;

    always #5 clk = ~clk;

    conv_seq_mem uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .wr_i(wr), .cfg_i(cfg),
        .conv_start_n_i(conv_n), .rd_i(rd), .cfg_o(cfg_o), .status_o(status_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] exp_cfg();
        return m[rp][6:1];
    endfunction

    task automatic check_outs(input string tag);
        chk({tag, " cfg_o"}, 32'(cfg_o), 32'(exp_cfg()));
        chk({tag, " status_o"}, 32'(status_o), 32'(m[rdp]));
    endtask

    task automatic set_mode(input logic [1:0] nm);
        @(negedge clk);
        mode = nm;
        if (nm != cur_mode) begin
            if (nm == 2'b01) wcnt = 0;
            if (nm == 2'b00) rp = 0;
            if (nm == 2'b10) rdp = 0;
        end
        cur_mode = nm;
        @(negedge clk);
    endtask

    task automatic wr_pulse(input logic [5:0] c);
        @(negedge clk);
        wr = 1'b1;
        cfg = c;
        @(negedge clk);
        wr = 1'b0;
        if (cur_mode == 2'b01 && wcnt < 16) begin
            if (wcnt > 0) m[wcnt-1][0] = 1'b0;
            m[wcnt] = {c, 1'b1};
            wcnt++;
        end
    endtask

    task automatic conv_pulse();
        @(negedge clk);
        conv_n = 1'b0;
        @(negedge clk);
        conv_n = 1'b1;
        if (cur_mode == 2'b00) begin
            if (m[rp][0] || rp == 15) rp = 0;
            else rp++;
        end
    endtask

    task automatic rd_pulse();
        @(negedge clk);
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        if (cur_mode == 2'b10) rdp = (rdp + 1) % 16;
    endtask

    task automatic program_list(input int n);
        set_mode(2'b01);
        for (int i = 0; i < n; i++) wr_pulse(6'($urandom_range(0, 63)));
    endtask

    task automatic read_all(input string tag);
        set_mode(2'b10);
        check_outs(tag);
        for (int i = 0; i < 17; i++) begin
            rd_pulse();
            check_outs(tag);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 16; i++) m[i] = '0;
        m[0] = 7'b0000001;
        wcnt = 0; rp = 0; rdp = 0; cur_mode = 2'b00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 cfg_o", 32'(cfg_o), 32'd0);
        chk("R1 status_o", 32'(status_o), 32'h01);

        // R2 R8: short directed list
        set_mode(2'b01);
        wr_pulse(6'b101101);
        wr_pulse(6'b010010);
        wr_pulse(6'b111111);
        read_all("R2 R8 directed");
        chk("R2 eos on last", 32'(m[2][0]), 32'd1);
        // R6 R7: playback wraps after the marked step
        set_mode(2'b00);
        check_outs("R6 run entry");
        for (int i = 0; i < 7; i++) begin
            conv_pulse();
            check_outs("R6 R7 playback");
        end

        // R5: stray writes in run and readback modes
        wr_pulse(6'b000111);
        check_outs("R5 write in run");
        set_mode(2'b10);
        wr_pulse(6'b110000);
        conv_pulse();
        check_outs("R6 edge in readback ignored");
        read_all("R5 memory unchanged");

        // R4: seventeen writes
        program_list(17);
        read_all("R4 full memory");
        chk("R4 loc15 eos", 32'(m[15][0]), 32'd1);
        set_mode(2'b00);
        for (int i = 0; i < 18; i++) begin
            conv_pulse();
            check_outs("R7 wrap at 15");
        end

        // R3: re-entry with a shorter list
        program_list(5);
        set_mode(2'b11);
        set_mode(2'b01);
        wr_pulse(6'b100001);
        wr_pulse(6'b011110);
        read_all("R3 restart at 0");
        set_mode(2'b00);
        for (int i = 0; i < 4; i++) begin
            conv_pulse();
            check_outs("R3 R7 short list playback");
        end

        // R9: idle mode freezes everything
        set_mode(2'b11);
        wr_pulse(6'b111000);
        conv_pulse();
        rd_pulse();
        check_outs("R9 idle");
        read_all("R9 memory after idle");

        // random rounds
        for (int r = 0; r < 25; r++) begin
            program_list(int'($urandom_range(1, 17)));
            if ($urandom_range(0, 1) == 1) begin
                set_mode(2'b11);
                rd_pulse();
                conv_pulse();
            end
            set_mode(2'b10);
            check_outs("R8 random read entry");
            for (int k = 0; k < int'($urandom_range(0, 20)); k++) begin
                if ($urandom_range(0, 3) == 0) wr_pulse(6'($urandom_range(0, 63)));
                else rd_pulse();
                check_outs("R8 R5 random read");
            end
            set_mode(2'b00);
            check_outs("R6 random run entry");
            for (int k = 0; k < int'($urandom_range(1, 24)); k++) begin
                if ($urandom_range(0, 4) == 0) rd_pulse();
                else conv_pulse();
                check_outs("R6 R7 random run");
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule